// File: doc/BRIEF.md
# Two-Class Priority Message Queue

This block sits at the receiving end of a link that carries coherence traffic of two classes over the same wires. Responses travel as the high class and requests travel as the low class. Each message arrives with a one-bit class tag. The block steers the message into one of two internal FIFOs according to that tag, so the classes never share storage.

The consumer side has a single valid/ready output. Whenever the high queue holds anything, the output presents the oldest high message. A low message is offered only while the high queue is empty. Within each class, messages leave in the order they arrived.

On the input side, ready depends only on the queue that the incoming tag selects. A full low queue therefore never holds up a response. Both queues have the same parameterized depth, and each reports its own full and empty flags.

Top module: `prio_link_queue`

## Requirements
- R1: While rst_n is low at a clock edge, both queues become empty: after that edge hi_empty=1, lo_empty=1, hi_full=0, lo_full=0 and out_valid=0.
- R2: in_ready reflects only the queue chosen by in_hi (in_hi=1 selects the high queue, in_hi=0 the low queue). It is 1 when that queue holds fewer than DEPTH entries, or when it is full and its head is being taken at the output in the same cycle.
- R3: Whenever the high queue holds at least one entry, out_valid=1, out_hi=1, and out_data is the oldest high entry.
- R4: A low entry is presented (out_valid=1 with out_hi=0) only when the high queue is empty.
- R5: Within each class, messages reach out_data in the order they were accepted, with none lost or duplicated. A transfer happens on a clock edge with valid and ready both high.
- R6: A full low queue does not lower in_ready for a high message.
- R7: A queue's full flag is 1 exactly when it holds DEPTH entries, and its empty flag is 1 exactly when it holds none.
- R8: A push into a full queue in the same cycle as a pop from that queue is accepted, and the queue stays full.
- R9: out_valid is 1 exactly when at least one of the two queues is non-empty.
- R10: While out_valid=1 and out_ready=0 on a high message, the next cycle still presents a high message with the same out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Queue selected by in_hi can take the message |
| in_hi | input | 1 | Class tag: 1 high (response), 0 low (request) |
| in_data | input | DATA_W | Incoming message payload |
| out_valid | output | 1 | A message is presented |
| out_ready | input | 1 | Consumer takes the presented message |
| out_hi | output | 1 | Class of the presented message |
| out_data | output | DATA_W | Presented message payload |
| hi_full | output | 1 | High queue holds DEPTH entries |
| hi_empty | output | 1 | High queue holds no entry |
| lo_full | output | 1 | Low queue holds DEPTH entries |
| lo_empty | output | 1 | Low queue holds no entry |

## Verification
The assertions assume that the producer keeps in_hi and in_data steady within a cycle, and that the consumer decides out_ready in the same cycle from the presented output. They also assume that both sides keep driving during reset. The bench changes every input only at the falling clock edge and holds in_valid and out_ready low during reset. It does not rely on the producer keeping a message valid until it is taken, because the design accepts or refuses each cycle on its own terms. The stimulus spans phases of heavy and light input load and of rare and frequent output draining, with varied class mixes, so that both queues spend long stretches full and empty.

// File: rtl/prio_link_queue_pkg.sv
// Shared types for the two-class link queue.
// Assumes: class tag encoding 1 = high (responses), 0 = low (requests).
package prio_link_queue_pkg;

    typedef enum logic {
        CLS_LOW  = 1'b0,
        CLS_HIGH = 1'b1
    } msg_class_e;

    // Convert a raw tag bit to a class
    function automatic msg_class_e tag_to_class(input logic tag);
        return tag ? CLS_HIGH : CLS_LOW;
    endfunction

endpackage

// File: rtl/plq_fifo.sv
// Single-clock FIFO with head presented combinationally.
// Assumes: DEPTH >= 2; push on a full FIFO is legal only together with pop;
// pop is issued only when not empty. Synchronous active-low reset.
module plq_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam bit POW2 = (DEPTH == (1 << AW));
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0]     count;

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise
    generate
        if (POW2) begin : g_wrap_nat
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Storage write
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Flags and head
    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

endmodule

// File: rtl/plq_steer.sv
// Input steering: routes an incoming message to the queue named by its tag
// and forms the input ready from that queue alone.
// Assumes: pop indications come from the output side in the same cycle.
module plq_steer
    import prio_link_queue_pkg::*;
(
    input  logic in_valid,
    input  logic in_hi,
    input  logic hi_full,
    input  logic lo_full,
    input  logic hi_pop,
    input  logic lo_pop,
    output logic in_ready,
    output logic hi_push,
    output logic lo_push
);
    msg_class_e cls;
    logic       hi_room, lo_room;

    // Room exists if not full or the head leaves this cycle
    always_comb begin
        cls     = tag_to_class(in_hi);
        hi_room = !hi_full || hi_pop;
        lo_room = !lo_full || lo_pop;
        in_ready = (cls == CLS_HIGH) ? hi_room : lo_room;
        hi_push  = in_valid && (cls == CLS_HIGH) && hi_room;
        lo_push  = in_valid && (cls == CLS_LOW)  && lo_room;
    end

endmodule

// File: rtl/plq_select.sv
// Output selection: presents the high head whenever the high queue holds
// anything, the low head otherwise, and forms the pop for the chosen queue.
// Assumes: heads are valid whenever the matching empty flag is low.
module plq_select #(
    parameter int DATA_W = 8
) (
    input  logic              hi_empty,
    input  logic              lo_empty,
    input  logic [DATA_W-1:0] hi_head,
    input  logic [DATA_W-1:0] lo_head,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_hi,
    output logic [DATA_W-1:0] out_data,
    output logic              hi_pop,
    output logic              lo_pop
);
    // Strict priority choice and dequeue
    always_comb begin
        out_hi    = !hi_empty;
        out_valid = !hi_empty || !lo_empty;
        out_data  = out_hi ? hi_head : lo_head;
        hi_pop    = out_ready && !hi_empty;
        lo_pop    = out_ready && hi_empty && !lo_empty;
    end

endmodule

// File: rtl/prio_link_queue.sv
// Two-class link queue: one tagged input, two FIFOs, strict-priority output.
// Assumes: single clock, synchronous active-low reset, DEPTH >= 2.
module prio_link_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_hi,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_hi,
    output logic [DATA_W-1:0] out_data,
    output logic              hi_full,
    output logic              hi_empty,
    output logic              lo_full,
    output logic              lo_empty
);
    localparam int NCLS = 2;

    logic [NCLS-1:0]   push_v, pop_v, full_v, empty_v;
    logic [DATA_W-1:0] head_v [NCLS];

    // One FIFO per class; index 1 is high, index 0 is low
    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_cls
            plq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push_v[c]),
                .push_data (in_data),
                .pop       (pop_v[c]),
                .head      (head_v[c]),
                .full      (full_v[c]),
                .empty     (empty_v[c])
            );
        end
    endgenerate

    plq_steer u_steer (
        .in_valid (in_valid),
        .in_hi    (in_hi),
        .hi_full  (full_v[1]),
        .lo_full  (full_v[0]),
        .hi_pop   (pop_v[1]),
        .lo_pop   (pop_v[0]),
        .in_ready (in_ready),
        .hi_push  (push_v[1]),
        .lo_push  (push_v[0])
    );

    plq_select #(.DATA_W(DATA_W)) u_sel (
        .hi_empty  (empty_v[1]),
        .lo_empty  (empty_v[0]),
        .hi_head   (head_v[1]),
        .lo_head   (head_v[0]),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_hi    (out_hi),
        .out_data  (out_data),
        .hi_pop    (pop_v[1]),
        .lo_pop    (pop_v[0])
    );

    // Flag outputs
    assign hi_full  = full_v[1];
    assign hi_empty = empty_v[1];
    assign lo_full  = full_v[0];
    assign lo_empty = empty_v[0];

endmodule

// File: rtl/prio_link_queue_chk.sv
// Property checker for prio_link_queue, attached by bind below.
module prio_link_queue_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_hi,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_hi,
    input logic [DATA_W-1:0] out_data,
    input logic              hi_full,
    input logic              hi_empty,
    input logic              lo_full,
    input logic              lo_empty
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (hi_empty && lo_empty && !out_valid));

    // R3
    hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_empty |-> (out_valid && out_hi));

    // R4
    lo_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hi) |-> hi_empty);

    // R6
    hi_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hi && lo_full && !hi_full) |-> in_ready);

    // R7
    hi_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_full && hi_empty));

    // R7
    lo_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_full && lo_empty));

    // R8
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_full && in_valid && in_hi && in_ready && out_valid && out_hi && out_ready)
        |=> hi_full);

    // R10
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hi && !out_ready) |=> (out_hi && $stable(out_data)));

endmodule

bind prio_link_queue prio_link_queue_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_hi     (in_hi),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_hi    (out_hi),
    .out_data  (out_data),
    .hi_full   (hi_full),
    .hi_empty  (hi_empty),
    .lo_full   (lo_full),
    .lo_empty  (lo_empty)
);

// File: tb/sim_prio_link_queue.sv
`timescale 1ns/1ps
module sim_prio_link_queue;
    localparam int DW = 8;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_hi = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, out_valid, out_hi;
    logic [DW-1:0] out_data;
    logic          hi_full, hi_empty, lo_full, lo_empty;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Bench-side reference queues
    logic [DW-1:0] hq [DP];
    logic [DW-1:0] lq [DP];
    int hcnt = 0, lcnt = 0;
    logic [DW-1:0] tagv = 8'h01;
    bit swap_prev = 1'b0;

    always #2.5 clk = ~clk;

    prio_link_queue #(.DATA_W(DW), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_hi(in_hi), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_hi(out_hi), .out_data(out_data),
        .hi_full(hi_full), .hi_empty(hi_empty), .lo_full(lo_full), .lo_empty(lo_empty)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then update the model at posedge
    task automatic step(input logic v, input logic h, input logic r);
        logic e_rdy, e_ov, e_oh, hpop, lpop, push;
        logic [DW-1:0] e_od;
        @(negedge clk);
        in_valid = v; in_hi = h; out_ready = r; in_data = tagv;
        #1;
        e_ov = (hcnt > 0) || (lcnt > 0);
        e_oh = (hcnt > 0);
        e_od = (hcnt > 0) ? hq[0] : lq[0];
        hpop = r && (hcnt > 0);
        lpop = r && (hcnt == 0) && (lcnt > 0);
        e_rdy = h ? ((hcnt < DP) || hpop) : ((lcnt < DP) || lpop);
        chk((h && lcnt == DP) ? "R6" : "R2", int'(in_ready), int'(e_rdy));
        chk("R9", int'(out_valid), int'(e_ov));
        if (e_ov) begin
            chk(e_oh ? "R3" : "R4", int'(out_hi), int'(e_oh));
            chk("R5", int'(out_data), int'(e_od));
        end
        chk(swap_prev ? "R8" : "R7", int'(hi_full), int'(hcnt == DP));
        chk("R7", int'(hi_empty), int'(hcnt == 0));
        chk("R7", int'(lo_full), int'(lcnt == DP));
        chk("R7", int'(lo_empty), int'(lcnt == 0));
        push = v && e_rdy;
        swap_prev = push && h && hpop && (hcnt == DP);
        @(posedge clk);
        if (hpop) begin
            for (int k = 0; k < DP - 1; k++) hq[k] = hq[k+1];
            hcnt--;
        end
        if (lpop) begin
            for (int k = 0; k < DP - 1; k++) lq[k] = lq[k+1];
            lcnt--;
        end
        if (push) begin
            if (h) begin hq[hcnt] = tagv; hcnt++; end
            else   begin lq[lcnt] = tagv; lcnt++; end
            tagv = tagv + 8'd1;
        end
    endtask

    initial begin
        logic [15:0] lf;
        int thr_in, thr_out, thr_hi;
        lf = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", int'(hi_empty), 1);
        chk("R1", int'(lo_empty), 1);
        chk("R1", int'(hi_full), 0);
        chk("R1", int'(lo_full), 0);
        chk("R1", int'(out_valid), 0);
        rst_n = 1'b1;
        // Directed: fill low, then high must still enter (R6)
        repeat (DP) step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);          // low refused while full, R2
        repeat (DP) step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);          // push+pop on full high queue, R8
        step(1'b0, 1'b0, 1'b0);
        repeat (3 * DP) step(1'b0, 1'b0, 1'b1);
        // Swept load phases
        for (int ph = 0; ph < 12; ph++) begin
            thr_in  = 4 + (ph % 3) * 5;
            thr_out = 2 + (ph % 4) * 4;
            thr_hi  = 1 + ((ph / 3) % 4) * 2;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(int'(lf[3:0]) < thr_in, int'(lf[11:9]) < thr_hi, int'(lf[7:4]) < thr_out);
            end
        end
        // Drain
        repeat (3 * DP) step(1'b0, 1'b0, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(5ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule